// File: doc/BRIEF.md
# Transition-Loaded Retriggerable Timer in a Five-Place Net Controller

This block is a small synchronous Petri net controller with one countdown timer wired into it. The net has five places and four transitions. The timer is started only by the firing of one transition, and its zero state becomes part of the firing condition of another transition. A firing is a transition condition true while all of that transition's input places hold a token. Every enabled transition fires on the same clock edge, so one edge settles the whole net.

The timer uses a time base taken from the system clock. A first divider counts clocks per millisecond. An optional second stage counts milliseconds per second. The time-unit preset is loaded when the trigger transition fires. The count then goes down by one on each time-base tick and stops at zero. Loading again while a count is running restarts it. The done flag stays low after reset until the timer has been loaded once. This stops a timer that never ran from looking expired.

Controller inputs pass through one register stage before they are used. The action outputs are computed from the next marking and are registered on the same edge as the marking, so every action changes at once.

Top module: `rlc_timed_net`

## Requirements
- R1: When reset is applied, the marking is one token in p1 (`mark_out` = 5'b00001), `act_out` = 0, `tmr_count` = 0 and `tmr_done` = 0.
- R2: An input change is stored in a register on the first clock edge. It can change the marking only on the next edge after that.
- R3: Places p1..p5 are `mark_out` bits 0..4. Inputs are `ev_in` bit 0 = go, bit 1 = b, bit 2 = c. The transitions are: T1 takes p1 to p2 and p3 when go. T2 takes p2 to p4 when c. T3 takes p3 to p5 when b and c. T4 takes p4 and p5 to p1 when go and the timer is done. Every enabled transition fires on the same edge. A token leaves a place only when a transition that consumes it fires.
- R4: `act_out` bit 0 is p2 OR p3, and bit 1 is p2 OR p5, both taken from the new marking. They change on the same edge as the marking.
- R5: On the edge where T3 fires, the count becomes PRESET (default 5).
- R6: After a load, the count goes down by one every CLK_PER_MS*MS_PER_S clocks (seconds mode). It reaches 0 exactly PRESET times that period after the load edge and then stays at 0.
- R7: A load while the count is not zero restarts both the count and the time-base phase from the start.
- R8: `tmr_done` is high only when the count is 0 and the timer has been loaded at least once since reset (with QUALIFY_DONE = 1).
- R9: T4 does not fire while `tmr_done` is low, even when p4 and p5 are marked and go is high. With go held high, T4 fires on the edge after done rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | 3 | Controller inputs: bit 0 go, bit 1 b, bit 2 c |
| act_out | output | 2 | Registered action outputs from the next marking |
| mark_out | output | 5 | Current marking, p1 in bit 0 |
| tmr_count | output | $clog2(PRESET+1) | Remaining time units |
| tmr_done | output | 1 | Timer expired, qualified by a past load |

## Verification
The assertions check these rules on every cycle:
- The count never exceeds the preset.
- The count falls by at most one per cycle unless a load occurs.
- A load always yields the preset on the next edge.
- Done implies a zero count.
- The outputs always match the marking.
- The return transition never fires while done is low.

Only the bench scenarios can show the following:
- The exact number of clocks from a load to expiry.
- The phase restart on retrigger.
- The one-edge input delay.
- The behaviour of the complete token flow over long random input runs, compared against a cycle model.

// File: rtl/rlc_pkg.sv
// Shared constants of the timed net controller: sizes, incidence
// matrices, output map and the index of the transition that loads
// the timer. Assumes a 1-safe net, places in bit order p1..p5.
package rlc_pkg;

    localparam int N_PLACE = 5;
    localparam int N_TRANS = 4;
    localparam int N_IN    = 3;
    localparam int N_OUT   = 2;

    // input bit positions
    localparam int IN_GO = 0;
    localparam int IN_B  = 1;
    localparam int IN_C  = 2;

    typedef logic [N_PLACE-1:0] mark_t;
    typedef logic [N_TRANS-1:0] trans_t;

    // places consumed by each transition (entry 0 = T1)
    localparam logic [N_TRANS-1:0][N_PLACE-1:0] PRE_M = {
        5'b11000,   // T4 consumes p4, p5
        5'b00100,   // T3 consumes p3
        5'b00010,   // T2 consumes p2
        5'b00001    // T1 consumes p1
    };

    // places produced by each transition
    localparam logic [N_TRANS-1:0][N_PLACE-1:0] POST_M = {
        5'b00001,   // T4 -> p1
        5'b10000,   // T3 -> p5
        5'b01000,   // T2 -> p4
        5'b00110    // T1 -> p2, p3
    };

    // places driving each action output
    localparam logic [N_OUT-1:0][N_PLACE-1:0] OUT_M = {
        5'b10010,   // action 1: p2 | p5
        5'b00110    // action 0: p2 | p3
    };

    localparam mark_t INIT_MARK  = 5'b00001;
    localparam int    LOAD_TRANS = 2;   // T3 loads the timer

endpackage

// File: rtl/rlc_tick_div.sv
// Time-base divider. Produces a one-cycle tick every CLK_PER_MS clocks
// (millisecond mode) or every CLK_PER_MS*MS_PER_S clocks (seconds mode).
// A clear input restarts the phase so that a freshly loaded timer sees
// a full first period. Assumes CLK_PER_MS >= 1 and MS_PER_S >= 1.
module rlc_tick_div #(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_PER_S   = 1000,
    parameter bit USE_SEC    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int MS_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam int S_W  = (MS_PER_S > 1)   ? $clog2(MS_PER_S)   : 1;
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(CLK_PER_MS - 1);
    localparam logic [S_W-1:0]  S_LAST  = S_W'(MS_PER_S - 1);

    logic [MS_W-1:0] ms_q;
    logic            ms_wrap;

    assign ms_wrap = (ms_q == MS_LAST);

    // millisecond stage: count clocks, wrap at the last one
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ms_q <= '0;
        end else if (ms_wrap) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_q + MS_W'(1);
        end
    end

    generate
        if (USE_SEC) begin : g_sec
            logic [S_W-1:0] s_q;
            logic           s_wrap;

            assign s_wrap = (s_q == S_LAST);

            // second stage: count millisecond wraps
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    s_q <= '0;
                end else if (ms_wrap) begin
                    s_q <= s_wrap ? '0 : s_q + S_W'(1);
                end
            end

            assign tick_o = ms_wrap && s_wrap;

            AST_SEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                s_q <= S_LAST);   // R6
        end else begin : g_ms
            assign tick_o = ms_wrap;
        end
    endgenerate

    AST_MS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST);   // R6

    AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && CLK_PER_MS > 1) |=> !tick_o);   // R7

endmodule

// File: rtl/rlc_timer.sv
// Retriggerable countdown timer. A load pulse sets the count to PRESET
// and restarts the time base. Each tick then lowers the count by one,
// stopping at zero. Done means zero and, if QUALIFY_DONE is set, loaded
// at least once since reset. Load wins over a tick in the same cycle.
module rlc_timer #(
    parameter int CLK_PER_MS   = 50000,
    parameter int MS_PER_S     = 1000,
    parameter bit USE_SEC      = 1'b1,
    parameter int PRESET       = 5,
    parameter bit QUALIFY_DONE = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    output logic [$clog2(PRESET+1)-1:0]     count_o,
    output logic                            done_o
);

    localparam int CNT_W = $clog2(PRESET + 1);
    localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(PRESET);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             tick;
    logic             zero;

    rlc_tick_div #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_S   (MS_PER_S),
        .USE_SEC    (USE_SEC)
    ) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (load_i),
        .tick_o (tick)
    );

    // count register: load has priority, decrement saturates at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= PRESET_V;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // armed flag: remembers that a load has happened since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (load_i) begin
            armed_q <= 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    generate
        if (QUALIFY_DONE) begin : g_qual
            assign done_o = zero && armed_q;
        end else begin : g_raw
            assign done_o = zero;
        end
    endgenerate

    assign count_o = cnt_q;

    AST_CNT_LE_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PRESET_V);   // R6

    AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == PRESET_V);   // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));   // R6

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> cnt_q == '0);   // R6

    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cnt_q == '0);   // R8

endmodule

// File: rtl/rlc_net_core.sv
// Net evaluation for the fixed five-place controller. Registers the raw
// inputs once, forms transition conditions, fires every enabled
// transition in one edge and registers the actions from the next
// marking. Exposes the firing of the loading transition as a
// combinational pulse. Assumes the net stays 1-safe.
module rlc_net_core
    import rlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   ev_raw,
    input  logic              tmr_done,
    output mark_t             mark_q,
    output logic [N_OUT-1:0]  act_q,
    output logic              load_o
);

    logic [N_IN-1:0]  ev_q;
    trans_t           cond;
    trans_t           fire;
    mark_t            produce;
    mark_t            consume;
    mark_t            mark_nx;
    logic [N_OUT-1:0] act_nx;

    // input stage: one register so conditions see settled values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_raw;
        end
    end

    // transition conditions, T4 includes the timer feedback
    always_comb begin
        cond[0] = ev_q[IN_GO];
        cond[1] = ev_q[IN_C];
        cond[2] = ev_q[IN_B] && ev_q[IN_C];
        cond[3] = ev_q[IN_GO] && tmr_done;
    end

    // firing: condition and every input place marked
    generate
        for (genvar t = 0; t < N_TRANS; t++) begin : g_fire
            assign fire[t] = cond[t] && ((mark_q & PRE_M[t]) == PRE_M[t]);
        end
    endgenerate

    // token flow: collect produced and consumed places over all firings
    always_comb begin
        produce = '0;
        consume = '0;
        for (int t = 0; t < N_TRANS; t++) begin
            if (fire[t]) begin
                produce = produce | POST_M[t];
                consume = consume | PRE_M[t];
            end
        end
        mark_nx = produce | (mark_q & ~consume);
    end

    // action map taken from the next marking
    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_act
            assign act_nx[o] = |(mark_nx & OUT_M[o]);
        end
    endgenerate

    // state update: marking and actions on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= INIT_MARK;
            act_q  <= '0;
        end else begin
            mark_q <= mark_nx;
            act_q  <= act_nx;
        end
    end

    assign load_o = fire[LOAD_TRANS];

    AST_MARK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q != '0);   // R3

    AST_ACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        act_q == {mark_q[1] | mark_q[4], mark_q[1] | mark_q[2]});   // R4

    AST_T4_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_q[3] && mark_q[4] && !tmr_done) |=> !mark_q[0]);   // R9

    AST_LOAD_NEEDS_P3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (mark_q[4] && !mark_q[2]));   // R5

endmodule

// File: rtl/rlc_timed_net.sv
// Top of the timed net controller: the net core with the countdown
// timer fed by the loading transition and its done flag fed back into
// the return transition condition.
module rlc_timed_net
    import rlc_pkg::*;
#(
    parameter int CLK_PER_MS   = 50000,
    parameter int MS_PER_S     = 1000,
    parameter bit USE_SEC      = 1'b1,
    parameter int PRESET       = 5,
    parameter bit QUALIFY_DONE = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    ev_in,
    output logic [1:0]                    act_out,
    output logic [4:0]                    mark_out,
    output logic [$clog2(PRESET+1)-1:0]   tmr_count,
    output logic                          tmr_done
);

    logic load;
    logic done;

    rlc_net_core net_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_raw   (ev_in),
        .tmr_done (done),
        .mark_q   (mark_out),
        .act_q    (act_out),
        .load_o   (load)
    );

    rlc_timer #(
        .CLK_PER_MS   (CLK_PER_MS),
        .MS_PER_S     (MS_PER_S),
        .USE_SEC      (USE_SEC),
        .PRESET       (PRESET),
        .QUALIFY_DONE (QUALIFY_DONE)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .count_o (tmr_count),
        .done_o  (done)
    );

    assign tmr_done = done;

endmodule

// File: tb/rlc_timed_net_tb.sv
module rlc_timed_net_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 2;
    localparam int MPS        = 3;
    localparam int PER        = CPM * MPS;
    localparam int PRE        = 5;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] e = 3'b000;
    logic [1:0] act;
    logic [4:0] mark;
    logic [2:0] cnt;
    logic       done;
    logic       tl = 1'b0;
    logic [2:0] t_cnt;
    logic       t_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlc_timed_net #(.CLK_PER_MS(CPM), .MS_PER_S(MPS), .USE_SEC(1'b1),
                    .PRESET(PRE), .QUALIFY_DONE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_in(e), .act_out(act),
        .mark_out(mark), .tmr_count(cnt), .tmr_done(done));

    rlc_timer #(.CLK_PER_MS(CPM), .MS_PER_S(MPS), .USE_SEC(1'b1),
                .PRESET(PRE), .QUALIFY_DONE(1'b1)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tl), .count_o(t_cnt), .done_o(t_done));

    task automatic chk(input string req, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act_v, exp_v, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // reference model state
    logic [2:0] m_eq;
    logic [4:0] m_mark;
    logic [1:0] m_out;
    int         m_cnt;
    bit         m_arm;
    int         m_ph;

    function automatic bit b_done(input int c, input bit arm);
        return (c == 0) && arm;
    endfunction

    function automatic logic [4:0] b_next(input logic [4:0] mk, input logic [2:0] eq, input bit dn);
        bit f1, f2, f3, f4, t1, t2, t3, t4;
        logic [4:0] nm;
        f1 = eq[0]; f2 = eq[2]; f3 = eq[1] & eq[2]; f4 = eq[0] & dn;
        t1 = f1 & mk[0]; t2 = f2 & mk[1]; t3 = f3 & mk[2]; t4 = f4 & mk[3] & mk[4];
        nm = mk;
        if (t1) nm[0] = 1'b0;
        if (t2) nm[1] = 1'b0;
        if (t3) nm[2] = 1'b0;
        if (t4) begin nm[3] = 1'b0; nm[4] = 1'b0; end
        if (t1) begin nm[1] = 1'b1; nm[2] = 1'b1; end
        if (t2) nm[3] = 1'b1;
        if (t3) nm[4] = 1'b1;
        if (t4) nm[0] = 1'b1;
        return nm;
    endfunction

    function automatic logic [1:0] b_act(input logic [4:0] mk);
        return {mk[1] | mk[4], mk[1] | mk[2]};
    endfunction

    // model update at each edge from the previous model state and driven inputs
    always @(posedge clk) begin : model
        bit ld, tk;
        logic [4:0] nm;
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_eq <= '0; m_mark <= 5'b00001; m_out <= '0;
            m_cnt <= 0; m_arm <= 1'b0; m_ph <= 0; cmp_on <= 1'b1;
        end else begin
            nm = b_next(m_mark, m_eq, b_done(m_cnt, m_arm));
            ld = m_eq[1] & m_eq[2] & m_mark[2];
            tk = (m_ph == PER - 1);
            m_out  <= b_act(nm);
            m_mark <= nm;
            m_eq   <= e;
            if (ld) begin
                m_cnt <= PRE; m_arm <= 1'b1; m_ph <= 0;
            end else begin
                m_ph <= tk ? 0 : m_ph + 1;
                if (tk && m_cnt != 0) m_cnt <= m_cnt - 1;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 marking", int'(mark), int'(m_mark));
            chk("R4 actions", int'(act), int'(m_out));
            chk("R6 count", int'(cnt), m_cnt);
            chk("R8 done", int'(done), int'(b_done(m_cnt, m_arm)));
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin : stim
        int n;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mark", int'(mark), 1);
        chk("R1 act", int'(act), 0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 done", int'(done), 0);
        chk("R8 unloaded done", int'(t_done), 0);
        rst_n = 1'b1;

        // R2: go needs two edges to move the token
        e = 3'b001;
        @(negedge clk);
        chk("R2 first edge", int'(mark), 5'b00001);
        @(negedge clk);
        chk("R2 second edge R3 T1", int'(mark), 5'b00110);
        chk("R4 act after T1", int'(act), 2'b11);

        // T2 only: p3, p4
        e = 3'b101;
        repeat (2) @(negedge clk);
        chk("R3 T2", int'(mark), 5'b01100);
        chk("R4 act p3p4", int'(act), 2'b01);

        // T3 loads the timer, go held high
        e = 3'b111;
        n = 0;
        while (mark != 5'b11000 && n < 10) begin @(negedge clk); n++; end
        chk("R3 T3", int'(mark), 5'b11000);
        chk("R5 preset", int'(cnt), PRE);
        chk("R4 act p4p5", int'(act), 2'b10);
        e = 3'b001;
        n = 0;
        while (!mark[0] && n < 200) begin
            if (n == 20) chk("R9 p1 empty before done", int'(mark[0]), 0);
            @(negedge clk); n++;
        end
        chk("R6 R9 load to return cycles", n, PRE * PER + 1);

        // R7: retrigger on the standalone timer
        @(negedge clk) tl = 1'b1;
        @(negedge clk) tl = 1'b0;
        chk("R5 timer preset", int'(t_cnt), PRE);
        repeat (10) @(negedge clk);
        chk("R6 timer after 10", int'(t_cnt), PRE - 1);
        tl = 1'b1;
        @(negedge clk) tl = 1'b0;
        chk("R7 reload", int'(t_cnt), PRE);
        repeat (PRE * PER - 1) @(negedge clk);
        chk("R7 not yet done", int'(t_done), 0);
        chk("R7 count one left", int'(t_cnt), 1);
        @(negedge clk);
        chk("R7 done after full period", int'(t_done), 1);
        repeat (2 * PER) @(negedge clk);
        chk("R6 saturates", int'(t_cnt), 0);
        chk("R8 stays done", int'(t_done), 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            if (($urandom % 4) == 0) r[0] = 1'b0;
            e = r;
            @(negedge clk);
        end
        finish_run();
    end

endmodule